// File: doc/BRIEF.md
# One-Dimensional Line Resizer

This block rescales one image line along a single axis. A line of SI 8-bit samples arrives on a valid/ready stream marked with start-of-line and end-of-line flags. The line is first shrunk by a power of two, using zero, one or two pair-averaging stages. The shrunken line is then resampled to SO samples by linear interpolation. The interpolation is driven by a fixed-point step with 13 fractional bits. A control unit derives the shrink exponent and the step from the requested sizes and rejects ratios the datapath cannot serve. It reports both values in one packed 16-bit word.

The sizes are read from `cfg_in_size` and `cfg_out_size` while a start-of-line sample waits at the input. Evaluation takes up to 16 cycles. During that time and for the rest of the line the block holds no other configuration. The input side has no flow control of its own: it accepts one sample every cycle while a line is loading, and `s_ready` stays low at every other time. The output side honours back-pressure fully: while `m_valid` is high and `m_ready` is low, the data and both markers hold. A new line can start only after the last output of the previous line has been taken.

Top module: `line_resizer_1d`

## Requirements
- R1: A configuration with input size 0, input size above 4096 or output size above 1024 raises `cfg_err` and is not streamed.
- R2: A configuration whose output size multiplied by 4 is smaller than the input size raises `cfg_err` and is not streamed.
- R3: The shrink exponent starts at 0. While the current size is above 1024, or is at least twice the output size, the size is halved (floor) and the exponent grows by one, at most twice. The exponent is therefore never 3.
- R4: The step equals floor(8192 × (shrunken size − 1) / (output size − 1)). A result of 16384 or more, or an output size of 1, gives 0x3FFF.
- R5: `coef_word` carries the exponent in bits [15:14] and the step in bits [13:0]. It is 0 after reset, changes only when a legal configuration has been evaluated, and keeps its value when a configuration is rejected.
- R6: Each shrink stage replaces each adjacent pair (a, b) by (a + b + 1) >> 1. An odd trailing sample is dropped.
- R7: Output k reads the position p = k × step. It takes samples A and B at indices i and i+1, where i = p >> 13, each index clamped to the last shrunken sample, and f = p mod 8192. The output is (A × (8192 − f) + B × f + 4096) >> 13.
- R8: Each line yields exactly SO outputs. `m_sol` marks the first output, which equals the first shrunken sample, and `m_eol` marks the last.
- R9: The sizes are read only while a start-of-line sample waits. Changes while a line loads or drains have no effect. While `cfg_err` is set, `s_ready` stays low, and the sizes are read again until a legal pair is found, which clears `cfg_err`.
- R10: While `m_valid` is high and `m_ready` is low, `m_data`, `m_sol` and `m_eol` hold. `s_ready` and `m_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_in_size | input | 13 | Requested input line length SI |
| cfg_out_size | input | 11 | Requested output line length SO |
| coef_word | output | 16 | Packed shrink exponent [15:14] and step [13:0] |
| cfg_err | output | 1 | Last evaluated configuration was illegal |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted this cycle |
| s_data | input | 8 | Input sample |
| s_sol | input | 1 | Input sample is the first of a line |
| s_eol | input | 1 | Input sample is the last of a line |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Sink takes the output sample |
| m_data | output | 8 | Output sample |
| m_sol | output | 1 | Output sample is the first of a line |
| m_eol | output | 1 | Output sample is the last of a line |

## Verification
A bad step or exponent shows in `coef_word` as soon as the line starts loading. It then skews the outputs from the second output onward. A broken pair average corrupts the very first output, because that output equals the first shrunken sample. An output counter that is off shows as a missing or extra sample, or as a misplaced `m_eol`, at the end of the same line. An error flag that is stuck either way shows within about twenty cycles, as `s_ready` failing to rise or as a rejected line being streamed.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  localparam int FRAC_W = 13;
  localparam int STEP_W = FRAC_W + 1;
  localparam logic [STEP_W-1:0] STEP_SAT = {STEP_W{1'b1}};
  typedef enum logic [1:0] {PH_IDLE, PH_CALC, PH_LOAD, PH_EMIT} phase_t;
endpackage

// File: rtl/rsz_ctrl.sv
module rsz_ctrl #(
  parameter int IN_W    = 13,
  parameter int OUT_W   = 11,
  parameter int MAX_IN  = 4096,
  parameter int MAX_OUT = 1024,
  parameter int MID_MAX = 1024,
  parameter int STAGES  = 2,
  parameter int EXP_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [IN_W-1:0]          si,
  input  logic [OUT_W-1:0]         so,
  output logic                     done,
  output logic                     err,
  output logic [EXP_W-1:0]         exp_o,
  output logic [rsz_pkg::STEP_W-1:0] step_o,
  output logic [OUT_W-1:0]         mid_sz,
  output logic [OUT_W-1:0]         out_sz
);
  import rsz_pkg::*;
  localparam int CW  = IN_W + 2;
  localparam int CNW = $clog2(STEP_W + 1);

  logic [IN_W-1:0]   si_q;
  logic              eval_q, run_q;
  logic [EXP_W-1:0]  exp_pend;
  logic [OUT_W-1:0]  rem_q;
  logic [STEP_W-1:0] nb_q, quo_q;
  logic [CNW-1:0]    cnt_q;

  logic [CW-1:0]     si_x, so2, so4, t_c;
  logic [EXP_W-1:0]  e_c;
  logic              bad, go, sat;
  logic [OUT_W-1:0]  mid_c, tm1, den;
  logic [OUT_W:0]    r2;
  logic              ge;
  logic [STEP_W-1:0] quo_n;

  always_comb begin
    si_x = CW'(si_q);
    so2  = CW'(out_sz) << 1;
    so4  = CW'(out_sz) << 2;
    bad  = (si_q == '0) || (si_x > CW'(MAX_IN)) ||
           (out_sz > OUT_W'(MAX_OUT)) || (so4 < si_x);
    t_c = si_x;
    e_c = '0;
    go  = 1'b1;
    for (int k = 0; k < STAGES; k++) begin
      if (go && ((t_c > CW'(MID_MAX)) || (t_c >= so2))) begin
        t_c = t_c >> 1;
        e_c = e_c + 1'b1;
      end else begin
        go = 1'b0;
      end
    end
    mid_c = t_c[OUT_W-1:0];
    tm1   = mid_c - 1'b1;
    den   = out_sz - 1'b1;
    sat   = (den == '0) || ({1'b0, tm1} >= {den, 1'b0});
    r2    = {rem_q, nb_q[STEP_W-1]};
    ge    = r2 >= {1'b0, den};
    quo_n = {quo_q[STEP_W-2:0], ge};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      si_q <= '0; out_sz <= '0; mid_sz <= '0;
      eval_q <= 1'b0; run_q <= 1'b0; done <= 1'b0; err <= 1'b0;
      exp_pend <= '0; exp_o <= '0; step_o <= '0;
      rem_q <= '0; nb_q <= '0; quo_q <= '0; cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        si_q   <= si;
        out_sz <= so;
        eval_q <= 1'b1;
      end else if (eval_q) begin
        eval_q <= 1'b0;
        if (bad) begin
          err  <= 1'b1;
          done <= 1'b1;
        end else begin
          mid_sz <= mid_c;
          if (sat) begin
            err    <= 1'b0;
            done   <= 1'b1;
            exp_o  <= e_c;
            step_o <= STEP_SAT;
          end else begin
            exp_pend <= e_c;
            rem_q    <= tm1 >> 1;
            nb_q     <= {tm1[0], {FRAC_W{1'b0}}};
            quo_q    <= '0;
            cnt_q    <= CNW'(STEP_W);
            run_q    <= 1'b1;
          end
        end
      end else if (run_q) begin
        rem_q <= ge ? OUT_W'(r2 - {1'b0, den}) : r2[OUT_W-1:0];
        nb_q  <= nb_q << 1;
        quo_q <= quo_n;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNW'(1)) begin
          run_q  <= 1'b0;
          done   <= 1'b1;
          err    <= 1'b0;
          exp_o  <= exp_pend;
          step_o <= quo_n;
        end
      end
    end
  end
endmodule

// File: rtl/rsz_halver.sv
module rsz_halver #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bypass,
  input  logic             in_v,
  input  logic [PIX_W-1:0] in_d,
  output logic             out_v,
  output logic [PIX_W-1:0] out_d
);
  logic             have_q;
  logic [PIX_W-1:0] hold_q;
  logic [PIX_W:0]   sum;

  always_comb begin
    sum   = {1'b0, hold_q} + {1'b0, in_d} + 1'b1;
    out_v = bypass ? in_v : (in_v && have_q);
    out_d = bypass ? in_d : sum[PIX_W:1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      have_q <= 1'b0;
      hold_q <= '0;
    end else if (in_v && !bypass) begin
      have_q <= !have_q;
      if (!have_q) hold_q <= in_d;
    end
  end
endmodule

// File: rtl/rsz_interp.sv
module rsz_interp #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 1024,
  parameter int OUT_W = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [PIX_W-1:0]           wr_d,
  input  logic                       start,
  input  logic [rsz_pkg::STEP_W-1:0] step,
  input  logic [OUT_W-1:0]           mid_sz,
  input  logic [OUT_W-1:0]           out_sz,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic [PIX_W-1:0]           m_data,
  output logic                       m_sol,
  output logic                       m_eol,
  output logic                       done
);
  import rsz_pkg::*;
  localparam int AW    = $clog2(DEPTH);
  localparam int POS_W = OUT_W + STEP_W;
  localparam int IX_W  = POS_W - FRAC_W;
  localparam int MW    = PIX_W + FRAC_W + 2;

  logic [PIX_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr;
  logic             run_q;
  logic [POS_W-1:0] pos_q;
  logic [OUT_W-1:0] cnt_q;

  logic [IX_W-1:0]   idx, lastix, ia, ib;
  logic [FRAC_W-1:0] frac;
  logic [PIX_W-1:0]  sa, sb;
  logic [MW-1:0]     mix;
  logic              last;

  always_comb begin
    idx    = pos_q[POS_W-1:FRAC_W];
    frac   = pos_q[FRAC_W-1:0];
    lastix = IX_W'(mid_sz) - 1'b1;
    ia     = (idx > lastix) ? lastix : idx;
    ib     = (idx >= lastix) ? lastix : idx + 1'b1;
    sa     = mem[ia[AW-1:0]];
    sb     = mem[ib[AW-1:0]];
    mix    = MW'(sa) * (MW'(1) << FRAC_W) - MW'(sa) * MW'(frac) +
             MW'(sb) * MW'(frac) + (MW'(1) << (FRAC_W - 1));
    last    = (cnt_q == out_sz - 1'b1);
    m_valid = run_q;
    m_data  = mix[FRAC_W +: PIX_W];
    m_sol   = run_q && (cnt_q == '0);
    m_eol   = run_q && last;
    done    = run_q && m_ready && last;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; run_q <= 1'b0; pos_q <= '0; cnt_q <= '0;
    end else begin
      if (clr) wptr <= '0;
      else if (wr_en) wptr <= wptr + 1'b1;
      if (start) begin
        run_q <= 1'b1;
        pos_q <= '0;
        cnt_q <= '0;
      end else if (run_q && m_ready) begin
        pos_q <= pos_q + POS_W'(step);
        cnt_q <= cnt_q + 1'b1;
        if (last) run_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/line_resizer_1d.sv
module line_resizer_1d #(
  parameter int PIX_W   = 8,
  parameter int MAX_IN  = 4096,
  parameter int MAX_OUT = 1024,
  parameter int MID_MAX = 1024,
  parameter int STAGES  = 2,
  localparam int IN_W   = $clog2(MAX_IN + 1),
  localparam int OUT_W  = $clog2(MAX_OUT + 1),
  localparam int EXP_W  = $clog2(STAGES + 1),
  localparam int CO_W   = EXP_W + rsz_pkg::STEP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  cfg_in_size,
  input  logic [OUT_W-1:0] cfg_out_size,
  output logic [CO_W-1:0]  coef_word,
  output logic             cfg_err,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_data,
  input  logic             s_sol,
  input  logic             s_eol,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_data,
  output logic             m_sol,
  output logic             m_eol
);
  import rsz_pkg::*;

  phase_t            ph_q;
  logic              start, c_done, c_err, s_fire, e_done;
  logic [EXP_W-1:0]  c_exp;
  logic [STEP_W-1:0] c_step;
  logic [OUT_W-1:0]  c_mid, c_out;
  logic              hv [STAGES+1];
  logic [PIX_W-1:0]  hd [STAGES+1];
  logic              clr;

  assign start     = (ph_q == PH_IDLE) && s_valid && s_sol;
  assign s_ready   = (ph_q == PH_LOAD);
  assign s_fire    = s_valid && s_ready;
  assign clr       = (ph_q != PH_LOAD);
  assign cfg_err   = c_err;
  assign coef_word = {c_exp, c_step};

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else begin
      unique case (ph_q)
        PH_IDLE: if (start) ph_q <= PH_CALC;
        PH_CALC: if (c_done) ph_q <= c_err ? PH_IDLE : PH_LOAD;
        PH_LOAD: if (s_fire && s_eol) ph_q <= PH_EMIT;
        PH_EMIT: if (e_done) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  rsz_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .MAX_IN(MAX_IN), .MAX_OUT(MAX_OUT),
             .MID_MAX(MID_MAX), .STAGES(STAGES), .EXP_W(EXP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .si(cfg_in_size), .so(cfg_out_size),
    .done(c_done), .err(c_err), .exp_o(c_exp), .step_o(c_step),
    .mid_sz(c_mid), .out_sz(c_out));

  assign hv[0] = s_fire;
  assign hd[0] = s_data;
  for (genvar k = 0; k < STAGES; k++) begin : g_half
    rsz_halver #(.PIX_W(PIX_W)) u_half (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .bypass(c_exp <= EXP_W'(k)),
      .in_v(hv[k]), .in_d(hd[k]), .out_v(hv[k+1]), .out_d(hd[k+1]));
  end

  rsz_interp #(.PIX_W(PIX_W), .DEPTH(MID_MAX), .OUT_W(OUT_W)) u_interp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(hv[STAGES]), .wr_d(hd[STAGES]),
    .start(s_fire && s_eol), .step(c_step), .mid_sz(c_mid), .out_sz(c_out),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sol(m_sol), .m_eol(m_eol), .done(e_done));
endmodule

// File: rtl/line_resizer_1d_chk.sv
module line_resizer_1d_chk #(
  parameter int PIX_W = 8,
  parameter int CO_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_err,
  input logic [CO_W-1:0]  coef_word,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_data,
  input logic             m_sol,
  input logic             m_eol
);
  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    coef_word[CO_W-1:CO_W-2] != 2'b11); // R3
  AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> $stable(coef_word)); // R5
  AST_FIRST_SOL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> m_sol); // R8
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !s_ready); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sol) && $stable(m_eol))); // R10
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_valid && s_ready)); // R10
endmodule

bind line_resizer_1d line_resizer_1d_chk #(.PIX_W(PIX_W), .CO_W(CO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .coef_word(coef_word),
  .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_sol(m_sol), .m_eol(m_eol));

// File: tb/line_resizer_1d_test.sv
module line_resizer_1d_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] cfg_in_size = '0;
  logic [10:0] cfg_out_size = '0;
  logic [15:0] coef_word;
  logic        cfg_err, s_ready, m_valid, m_sol, m_eol;
  logic        s_valid = 1'b0, s_sol = 1'b0, s_eol = 1'b0, m_ready = 1'b0;
  logic [7:0]  s_data = '0;
  logic [7:0]  m_data;

  int errors = 0, checks = 0, cyc = 0, outk = 0;
  bit bp = 1'b0, finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int exq[$];

  always #10 clk = ~clk;

  line_resizer_1d uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pix(input int i, input int seed);
    return (i * 37 + seed * 11 + (i * i) % 13) & 255;
  endfunction

  // model of R1..R4
  task automatic model(input int si, input int so, output int e, output int st, output bit bad);
    int t;
    bad = (si == 0) || (si > 4096) || (so > 1024) || (so * 4 < si);
    t = si; e = 0;
    while (((t > 1024) || (t >= 2 * so)) && e < 2) begin t = t >> 1; e++; end
    if (so <= 1) st = 16383;
    else begin
      st = (8192 * (t - 1)) / (so - 1);
      if (st >= 16384) st = 16383;
    end
  endtask

  // monitor: scoreboard pop and compare (R7, R8)
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
    #1;
    if (rst_n && m_valid && m_ready) begin
      if (exq.size() == 0) chk(1'b0, "R8 extra output", int'(m_data), -1);
      else begin
        int e;
        e = exq.pop_front();
        chk({m_sol, m_eol, m_data} == e[9:0], "R7/R8 output", int'({m_sol, m_eol, m_data}), e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic send_line(input int si, input int seed, input bit scramble);
    for (int i = 0; i < si; i++) begin
      @(negedge clk);
      if (scramble && i == 1) begin cfg_in_size = 13'd7; cfg_out_size = 11'd3; end
      s_valid = 1'b1; s_data = 8'(pix(i, seed)); s_sol = (i == 0); s_eol = (i == si - 1);
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    s_valid = 1'b0; s_sol = 1'b0; s_eol = 1'b0;
  endtask

  task automatic run_line(input int si, input int so, input int seed, input bit bpm,
                          input bit scramble, input string tag);
    int e, st, n;
    bit bad;
    int cur[$], nxt[$];
    model(si, so, e, st, bad);
    for (int i = 0; i < si; i++) cur.push_back(pix(i, seed));
    for (int s = 0; s < e; s++) begin
      nxt.delete();
      for (int i = 0; i < cur.size() / 2; i++) nxt.push_back((cur[2*i] + cur[2*i+1] + 1) >> 1);
      cur = nxt;
    end
    n = cur.size();
    for (int k = 0; k < so; k++) begin
      int p, ix, f, ia, ib, v;
      p = k * st; ix = p >> 13; f = p & 8191;
      ia = (ix > n - 1) ? n - 1 : ix;
      ib = (ix + 1 > n - 1) ? n - 1 : ix + 1;
      v = (cur[ia] * (8192 - f) + cur[ib] * f + 4096) >> 13;
      exq.push_back(((k == 0) << 9) | ((k == so - 1) << 8) | v);
    end
    cfg_in_size = 13'(si); cfg_out_size = 11'(so); bp = bpm;
    send_line(si, seed, scramble);
    for (int w = 0; w < 20000 && exq.size() != 0; w++) @(negedge clk);
    chk(exq.size() == 0, {tag, " R8 missing outputs"}, exq.size(), 0);
    exq.delete();
    @(negedge clk); #2;
    chk(coef_word == 16'((e << 14) | st), {tag, " R3/R4/R5 coef"}, int'(coef_word), (e << 14) | st);
    chk(cfg_err == 1'b0, {tag, " R9 err clear"}, int'(cfg_err), 0);
    chk(m_valid == 1'b0, {tag, " R8 no extra"}, int'(m_valid), 0);
  endtask

  task automatic err_probe(input int si, input int so, input int seed, input string tag);
    logic [15:0] old;
    old = coef_word;
    cfg_in_size = 13'(si); cfg_out_size = 11'(so);
    @(negedge clk);
    s_valid = 1'b1; s_sol = 1'b1; s_eol = 1'b0; s_data = 8'(pix(0, seed));
    repeat (40) @(negedge clk);
    #2;
    chk(cfg_err == 1'b1, {tag, " err flag"}, int'(cfg_err), 1);
    chk(s_ready == 1'b0, {tag, " R9 blocked"}, int'(s_ready), 0);
    chk(m_valid == 1'b0, {tag, " R9 no output"}, int'(m_valid), 0);
    chk(coef_word == old, {tag, " R5 coef kept"}, int'(coef_word), int'(old));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(s_ready == 1'b0 && m_valid == 1'b0, "reset R10 idle", int'({s_ready, m_valid}), 0);
    chk(coef_word == 16'h0 && cfg_err == 1'b0, "reset R5", int'(coef_word), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_line(8, 8, 1, 1'b0, 1'b0, "R7 identity");
    run_line(16, 8, 2, 1'b0, 1'b0, "R6 one halving");
    run_line(9, 4, 3, 1'b0, 1'b0, "R6 odd drop");
    run_line(16, 4, 4, 1'b0, 1'b0, "R3 two halvings");
    run_line(5, 9, 5, 1'b1, 1'b0, "R10 upscale bp");
    run_line(10, 7, 6, 1'b0, 1'b0, "R7 fraction");
    run_line(3, 2, 7, 1'b0, 1'b0, "R4 sat");
    run_line(1, 1, 8, 1'b1, 1'b0, "R4 single");
    err_probe(20, 4, 9, "R2 ratio");
    run_line(20, 5, 9, 1'b0, 1'b0, "R9 recover");
    err_probe(5000, 1024, 10, "R1 in max");
    run_line(4096, 1024, 10, 1'b1, 1'b1, "R9 scramble R3 big");
    err_probe(100, 1100, 11, "R1 out max");
    err_probe(0, 10, 11, "R1 zero");
    run_line(2048, 600, 11, 1'b0, 1'b0, "R4 divide");
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule